// File: doc/BRIEF.md
# Stream to Parallel Video Output Synchronizer

This block turns a packetised pixel stream (data, valid, ready, start-of-frame user flag, end-of-line flag and a field bit) back into a parallel video signal that matches an external raster timing generator. Stream beats are written into a dual-clock FIFO on the stream clock. On the pixel clock, an alignment engine reads the FIFO in step with the generator's active-video indication. It then outputs each pixel in the same cycle as the forwarded hsync, hblank, vsync, vblank, active and field signals. The stream clock is expected to run at or above the pixel clock.

The engine has two ways to bring the stream into line with the raster. In slave mode it holds the generator's clock enable low after reset. It raises the enable only when a start-of-frame beat sits at the FIFO head, so the generator's first active pixel takes that beat. In master mode the generator runs freely. The engine only waits for the first active cycle after a vertical blank before it starts reading. A start-of-frame-pending output tells the generator that a frame start is waiting. If the FIFO runs dry during active video, a sticky underflow flag is set, black pixels are sent, and alignment is sought again at the next start-of-frame beat.

The single reset `rst_ni` is asynchronous and clears both clock domains. `master_mode_i` is static and is changed only while reset is held.

Top module: `stream_video_out`

## Requirements
- R1: While reset is held and just after it: `tg_ce_o` is 0 in slave mode and 1 in master mode, and `vid_data_o`, `vid_active_o`, `underflow_o` and `sof_pending_o` are 0.
- R2: A beat is stored on each stream clock edge where `s_tvalid_i` and `s_tready_o` are both 1. `s_tready_o` is 0 when the FIFO holds 2**FIFO_AW entries. Beats leave the FIFO in arrival order.
- R3: While alignment is being sought, a beat at the FIFO head with `s_tuser_i` = 0 is discarded and never shows up on `vid_data_o`.
- R4: Slave mode: `tg_ce_o` stays 0 until a beat with `s_tuser_i` = 1 reaches the FIFO head. It then becomes 1 and stays 1 until reset. That beat is output on the generator's first active cycle with the enable high.
- R5: Master mode: `tg_ce_o` is 1 at all times. Reading starts on the first `tg_active_i` cycle that follows a `tg_vblank_i` cycle, and active cycles before that carry zero pixels.
- R6: `sof_pending_o` is 1 while a start-of-frame beat is at the FIFO head waiting for its alignment point.
- R7: `vid_active_o`, `vid_hblank_o`, `vid_vblank_o`, `vid_hsync_o`, `vid_vsync_o` and `vid_field_o` equal the matching `tg_*` inputs delayed by exactly one pixel clock.
- R8: A beat that is read appears on `vid_data_o`, `vid_sfield_o` (its field bit) and `vid_eol_o` (its end-of-line bit) in the same cycle as its `vid_active_o`. When `vid_active_o` is 0, `vid_data_o` is 0.
- R9: If the FIFO is empty on an active cycle after alignment, `vid_data_o` is 0 for that pixel and `underflow_o` becomes 1 and stays 1 until reset. Reading then resumes at the first frame start after the next start-of-frame beat, and not before alignment is first reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk_i | input | 1 | Stream clock |
| pix_clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| master_mode_i | input | 1 | 1 selects master alignment, 0 selects slave |
| s_tdata_i | input | DATA_W | Stream pixel data |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | FIFO can accept a beat |
| s_tuser_i | input | 1 | Start-of-frame flag of the beat |
| s_tlast_i | input | 1 | End-of-line flag of the beat |
| s_field_i | input | 1 | Field bit carried with the beat |
| tg_active_i | input | 1 | Generator active video |
| tg_hblank_i | input | 1 | Generator horizontal blank |
| tg_vblank_i | input | 1 | Generator vertical blank |
| tg_hsync_i | input | 1 | Generator horizontal sync |
| tg_vsync_i | input | 1 | Generator vertical sync |
| tg_field_i | input | 1 | Generator field bit |
| tg_ce_o | output | 1 | Clock enable to the generator |
| sof_pending_o | output | 1 | Start-of-frame beat waiting for alignment |
| vid_data_o | output | DATA_W | Output pixel |
| vid_active_o | output | 1 | Delayed active video |
| vid_hblank_o | output | 1 | Delayed horizontal blank |
| vid_vblank_o | output | 1 | Delayed vertical blank |
| vid_hsync_o | output | 1 | Delayed horizontal sync |
| vid_vsync_o | output | 1 | Delayed vertical sync |
| vid_field_o | output | 1 | Delayed generator field bit |
| vid_sfield_o | output | 1 | Field bit of the output beat |
| vid_eol_o | output | 1 | End-of-line bit of the output beat |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench builds the block with DATA_W = 8 and FIFO_AW = 3. An eight-entry FIFO fills within a few beats while master mode waits for the next frame, so backpressure and the full condition can be reached. It drives a small behavioural raster of 8 clocks by 5 lines with 4 by 3 active pixels, which it halts through the clock enable. The short frame lets several frame starts, an underflow and a realignment happen in a few hundred pixel clocks. The stream clock runs faster than the pixel clock, so pointer-crossing latency is present without starving the display within a frame.

// File: rtl/svo_pkg.sv
package svo_pkg;

  typedef enum logic [1:0] {
    AL_HUNT = 2'd0,
    AL_ARM  = 2'd1,
    AL_RUN  = 2'd2
  } al_state_e;

  typedef struct packed {
    logic act;
    logic hblank;
    logic vblank;
    logic hsync;
    logic vsync;
    logic field;
  } vtime_t;

endpackage

// File: rtl/svo_sync.sv
module svo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sr_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= '0;
        else         sr_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= '0;
        else         sr_q[g] <= sr_q[g-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/svo_afifo.sv
module svo_afifo #(
  parameter int DW = 8,
  parameter int AW = 4   // must be >= 2
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  input  logic          rclk_i,
  input  logic          rpop_i,
  output logic [DW-1:0] rdata_o,
  output logic          rempty_o
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx;
  logic [PW-1:0] rgray_w, wgray_r;
  logic          wr_en, rd_en;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // write domain
  assign wr_en   = wvalid_i & wready_o;
  assign wbin_nx = wbin_q + PW'(wr_en);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= b2g(wbin_nx);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  svo_sync #(.W(PW), .STAGES(2)) i_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray_q),
    .q_o    (rgray_w)
  );

  // full: top two gray bits inverted, rest equal
  assign wready_o = (wgray_q != {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  // read domain, show-ahead head
  assign rd_en   = rpop_i & ~rempty_o;
  assign rbin_nx = rbin_q + PW'(rd_en);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= b2g(rbin_nx);
    end
  end

  svo_sync #(.W(PW), .STAGES(2)) i_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray_q),
    .q_o    (wgray_r)
  );

  assign rempty_o = (rgray_q == wgray_r);
  assign rdata_o  = mem[rbin_q[AW-1:0]];

  a_r2_no_pop_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rpop_i |-> !rempty_o);

  a_r2_gray_single_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

endmodule

// File: rtl/svo_align.sv
module svo_align
  import svo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  vtime_t        tm_i,
  input  logic [DW-1:0] head_data_i,
  input  logic          head_user_i,
  input  logic          head_last_i,
  input  logic          head_fld_i,
  input  logic          empty_i,
  output logic          pop_o,
  output logic          ce_o,
  output logic          sof_pend_o,
  output logic          uflow_o,
  output vtime_t        tm_o,
  output logic [DW-1:0] data_o,
  output logic          sfld_o,
  output logic          eol_o
);

  al_state_e st_q, st_d;
  logic      vb_seen_q, locked_q, uflow_q;
  logic      frame_start, start, rd_px, under;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vb_seen_q <= 1'b0;
    else if (tm_i.vblank) vb_seen_q <= 1'b1;
    else if (tm_i.act)    vb_seen_q <= 1'b0;
  end

  assign frame_start = tm_i.act & vb_seen_q;
  // first slave lock takes the halted generator's current active pixel
  assign start       = (master_i || locked_q) ? frame_start : tm_i.act;
  assign under       = (st_q == AL_RUN) && tm_i.act && empty_i;

  always_comb begin
    st_d  = st_q;
    pop_o = 1'b0;
    rd_px = 1'b0;
    unique case (st_q)
      AL_HUNT: begin
        if (!empty_i) begin
          if (head_user_i) st_d  = AL_ARM;
          else             pop_o = 1'b1;
        end
      end
      AL_ARM: begin
        if (start) begin
          pop_o = 1'b1;
          rd_px = 1'b1;
          st_d  = AL_RUN;
        end
      end
      AL_RUN: begin
        if (tm_i.act) begin
          if (empty_i) begin
            st_d = AL_HUNT;
          end else begin
            pop_o = 1'b1;
            rd_px = 1'b1;
          end
        end
      end
      default: st_d = AL_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= AL_HUNT;
      locked_q <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == AL_ARM && start) locked_q <= 1'b1;
      if (under)                   uflow_q  <= 1'b1;
    end
  end

  // one register stage for pixel and timing alike
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_o   <= '0;
      data_o <= '0;
      sfld_o <= 1'b0;
      eol_o  <= 1'b0;
    end else begin
      tm_o   <= tm_i;
      data_o <= rd_px ? head_data_i : '0;
      sfld_o <= rd_px & head_fld_i;
      eol_o  <= rd_px & head_last_i;
    end
  end

  assign ce_o       = master_i | locked_q | (st_q == AL_ARM);
  assign sof_pend_o = (st_q == AL_ARM);
  assign uflow_o    = uflow_q;

  a_r4_ce_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o && !(st_q == AL_ARM)) |=> ce_o);

  a_r6_sof_at_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_pend_o |-> (!empty_i && head_user_i));

  a_r8_data_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0) |-> tm_o.act);

  a_r9_zero_on_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == AL_RUN) && tm_i.act && empty_i) |=> (data_o == '0 && uflow_o));

  a_r9_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> uflow_o);

endmodule

// File: rtl/stream_video_out.sv
module stream_video_out
  import svo_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int FIFO_AW = 4
) (
  input  logic              s_clk_i,
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic              master_mode_i,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic              s_tuser_i,
  input  logic              s_tlast_i,
  input  logic              s_field_i,
  input  logic              tg_active_i,
  input  logic              tg_hblank_i,
  input  logic              tg_vblank_i,
  input  logic              tg_hsync_i,
  input  logic              tg_vsync_i,
  input  logic              tg_field_i,
  output logic              tg_ce_o,
  output logic              sof_pending_o,
  output logic [DATA_W-1:0] vid_data_o,
  output logic              vid_active_o,
  output logic              vid_hblank_o,
  output logic              vid_vblank_o,
  output logic              vid_hsync_o,
  output logic              vid_vsync_o,
  output logic              vid_field_o,
  output logic              vid_sfield_o,
  output logic              vid_eol_o,
  output logic              underflow_o
);

  localparam int EW = DATA_W + 3;

  logic [EW-1:0] wr_word, head_word;
  logic          fifo_empty, fifo_pop;
  vtime_t        tm_in, tm_out;

  assign wr_word = {s_field_i, s_tlast_i, s_tuser_i, s_tdata_i};

  svo_afifo #(.DW(EW), .AW(FIFO_AW)) i_fifo (
    .wclk_i   (s_clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (wr_word),
    .wvalid_i (s_tvalid_i),
    .wready_o (s_tready_o),
    .rclk_i   (pix_clk_i),
    .rpop_i   (fifo_pop),
    .rdata_o  (head_word),
    .rempty_o (fifo_empty)
  );

  assign tm_in = '{act: tg_active_i, hblank: tg_hblank_i, vblank: tg_vblank_i,
                   hsync: tg_hsync_i, vsync: tg_vsync_i, field: tg_field_i};

  svo_align #(.DW(DATA_W)) i_align (
    .clk_i       (pix_clk_i),
    .rst_ni      (rst_ni),
    .master_i    (master_mode_i),
    .tm_i        (tm_in),
    .head_data_i (head_word[DATA_W-1:0]),
    .head_user_i (head_word[DATA_W]),
    .head_last_i (head_word[DATA_W+1]),
    .head_fld_i  (head_word[DATA_W+2]),
    .empty_i     (fifo_empty),
    .pop_o       (fifo_pop),
    .ce_o        (tg_ce_o),
    .sof_pend_o  (sof_pending_o),
    .uflow_o     (underflow_o),
    .tm_o        (tm_out),
    .data_o      (vid_data_o),
    .sfld_o      (vid_sfield_o),
    .eol_o       (vid_eol_o)
  );

  assign vid_active_o = tm_out.act;
  assign vid_hblank_o = tm_out.hblank;
  assign vid_vblank_o = tm_out.vblank;
  assign vid_hsync_o  = tm_out.hsync;
  assign vid_vsync_o  = tm_out.vsync;
  assign vid_field_o  = tm_out.field;

endmodule

// File: tb/test_stream_video_out.sv
module test_stream_video_out;

  localparam int CLK_PERIOD = 10;
  localparam int S_PERIOD   = 6;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int H_TOT = 8, H_ACT = 4, V_TOT = 5, V_ACT = 3;
  localparam int PPF = H_ACT * V_ACT;
  localparam int NOBS = 1024;

  logic s_clk = 1'b0, pix_clk = 1'b0, rst_n = 1'b0, master = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0, s_field = 1'b0;
  logic s_tready, tg_ce_o, sof_pending_o, underflow_o;
  logic [DW-1:0] vid_data_o;
  logic vid_active_o, vid_hblank_o, vid_vblank_o, vid_hsync_o, vid_vsync_o, vid_field_o;
  logic vid_sfield_o, vid_eol_o;

  int hc, vc, frm;
  logic ce_n, ce_q, mon_en, sof_seen;
  logic [5:0] tg_q;
  logic tg_act, tg_hb, tg_vb, tg_hs, tg_vs, tg_fl;

  logic [DW-1:0] obs_d [NOBS];
  logic obs_f [NOBS];
  logic obs_l [NOBS];
  int n_obs, tmis, zbad, ce_drop;
  int errors = 0, checks = 0;

  assign tg_act = (hc < H_ACT) && (vc < V_ACT);
  assign tg_hb  = (hc >= H_ACT);
  assign tg_vb  = (vc >= V_ACT);
  assign tg_hs  = (hc == 5) || (hc == 6);
  assign tg_vs  = (vc == V_TOT - 1);
  assign tg_fl  = frm[0];

  stream_video_out #(.DATA_W(DW), .FIFO_AW(AW)) i_stream_video_out (
    .s_clk_i(s_clk), .pix_clk_i(pix_clk), .rst_ni(rst_n), .master_mode_i(master),
    .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
    .s_tuser_i(s_tuser), .s_tlast_i(s_tlast), .s_field_i(s_field),
    .tg_active_i(tg_act), .tg_hblank_i(tg_hb), .tg_vblank_i(tg_vb),
    .tg_hsync_i(tg_hs), .tg_vsync_i(tg_vs), .tg_field_i(tg_fl),
    .tg_ce_o(tg_ce_o), .sof_pending_o(sof_pending_o),
    .vid_data_o(vid_data_o), .vid_active_o(vid_active_o), .vid_hblank_o(vid_hblank_o),
    .vid_vblank_o(vid_vblank_o), .vid_hsync_o(vid_hsync_o), .vid_vsync_o(vid_vsync_o),
    .vid_field_o(vid_field_o), .vid_sfield_o(vid_sfield_o), .vid_eol_o(vid_eol_o),
    .underflow_o(underflow_o)
  );

  initial forever #(S_PERIOD / 2) s_clk = ~s_clk;
  initial forever #(CLK_PERIOD / 2) pix_clk = ~pix_clk;

  // behavioural raster generator, advanced by the enable seen mid-cycle
  initial begin
    hc = 0; vc = 0; frm = 0; ce_q = 1'b0; tg_q = '0;
    forever begin
      @(posedge pix_clk);
      tg_q <= {tg_act, tg_hb, tg_vb, tg_hs, tg_vs, tg_fl};
      ce_q <= ce_n;
      if (!rst_n) begin
        hc <= 0; vc <= 0; frm <= 0;
      end else if (ce_n) begin
        if (hc == H_TOT - 1) begin
          hc <= 0;
          if (vc == V_TOT - 1) begin vc <= 0; frm <= frm + 1; end
          else vc <= vc + 1;
        end else hc <= hc + 1;
      end
    end
  end

  // output monitor
  initial begin
    ce_n = 1'b0; mon_en = 1'b0; sof_seen = 1'b0;
    n_obs = 0; tmis = 0; zbad = 0; ce_drop = 0;
    forever begin
      @(negedge pix_clk);
      ce_n = tg_ce_o;
      if (mon_en) begin
        if ({vid_active_o, vid_hblank_o, vid_vblank_o, vid_hsync_o, vid_vsync_o, vid_field_o} != tg_q)
          tmis++;
        if (!vid_active_o && vid_data_o != '0) zbad++;
        if (master && !tg_ce_o) ce_drop++;
        if (sof_pending_o) sof_seen = 1'b1;
        if (vid_active_o && ce_q && n_obs < NOBS) begin
          obs_d[n_obs] = vid_data_o;
          obs_f[n_obs] = vid_sfield_o;
          obs_l[n_obs] = vid_eol_o;
          n_obs++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    mon_en = 1'b0;
    @(negedge pix_clk);
    rst_n = 1'b0;
    master = mode;
    repeat (4) @(negedge pix_clk);
    chk(tg_ce_o == mode, "R1 enable in reset", int'(tg_ce_o), int'(mode));
    chk(vid_data_o == '0 && !vid_active_o, "R1 outputs in reset", int'(vid_data_o), 0);
    chk(!underflow_o && !sof_pending_o, "R1 flags in reset",
        int'({underflow_o, sof_pending_o}), 0);
    rst_n = 1'b1;
    @(posedge pix_clk);
    #1;
    n_obs = 0; tmis = 0; zbad = 0; ce_drop = 0; sof_seen = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic send_beat(input logic [DW-1:0] d, input logic u, input logic l, input logic f);
    @(negedge s_clk);
    s_tdata = d; s_tuser = u; s_tlast = l; s_field = f; s_tvalid = 1'b1;
    while (!s_tready) @(negedge s_clk);
    @(posedge s_clk);
  endtask

  task automatic send_idle();
    @(negedge s_clk);
    s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic send_range(input int base, input logic f, input int first, input int last);
    for (int i = first; i <= last; i++)
      send_beat(DW'(base + i), (i == 0), (i % H_ACT == H_ACT - 1), f);
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) send_beat(8'hEE, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_slave();
    int bad, k;
    do_reset(1'b0);
    repeat (20) @(negedge pix_clk);
    chk(tg_ce_o == 1'b0, "R4 enable held low", int'(tg_ce_o), 0);
    chk(hc == 0 && vc == 0, "R4 generator halted", hc + vc, 0);
    send_junk(2);
    send_range(8'h01, 1'b0, 0, PPF - 1);
    send_idle();
    repeat (70) @(negedge pix_clk);
    chk(sof_seen, "R6 pending seen in slave", int'(sof_seen), 1);
    chk(n_obs > PPF, "R4 pixel count", n_obs, PPF + 1);
    bad = 0;
    for (int i = 0; i < PPF; i++) if (obs_d[i] != DW'(8'h01 + i)) bad++;
    chk(bad == 0, "R3 R4 first frame aligned", int'(obs_d[0]), 8'h01);
    chk(obs_l[3] && obs_l[7] && obs_l[11] && !obs_l[0], "R8 end of line",
        int'({obs_l[3], obs_l[7], obs_l[11], obs_l[0]}), 4'b1110);
    chk(obs_d[PPF] == '0, "R9 zero pixel on underflow", int'(obs_d[PPF]), 0);
    chk(underflow_o == 1'b1, "R9 underflow flag", int'(underflow_o), 1);
    chk(tg_ce_o == 1'b1, "R4 enable stays high", int'(tg_ce_o), 1);
    send_range(8'h41, 1'b0, 0, PPF - 1);
    send_idle();
    repeat (130) @(negedge pix_clk);
    k = -1;
    for (int i = PPF; i < n_obs; i++) if (k < 0 && obs_d[i] == 8'h41) k = i;
    chk(k > 0 && k % PPF == 0, "R9 realign at frame start", k, 2 * PPF);
    bad = 0;
    if (k > 0) for (int i = 0; i < PPF; i++) if (obs_d[k + i] != DW'(8'h41 + i)) bad++;
    chk(k > 0 && bad == 0, "R9 realigned frame order", bad, 0);
    chk(underflow_o == 1'b1, "R9 flag sticky", int'(underflow_o), 1);
    chk(tmis == 0, "R7 timing delay slave", tmis, 0);
    chk(zbad == 0, "R8 zero outside active slave", zbad, 0);
  endtask

  task automatic t_master();
    int bad, bf;
    do_reset(1'b1);
    chk(tg_ce_o == 1'b1, "R5 enable high", int'(tg_ce_o), 1);
    send_junk(3);
    send_range(8'h21, 1'b1, 0, 7);
    repeat (4) @(negedge s_clk);
    chk(s_tready == 1'b0, "R2 ready low when full", int'(s_tready), 0);
    chk(sof_pending_o == 1'b1, "R6 pending waits for frame", int'(sof_pending_o), 1);
    chk(underflow_o == 1'b0, "R9 no underflow before lock", int'(underflow_o), 0);
    send_range(8'h21, 1'b1, 8, PPF - 1);
    send_idle();
    repeat (120) @(negedge pix_clk);
    chk(n_obs > 2 * PPF, "R5 pixel count", n_obs, 2 * PPF + 1);
    bad = 0;
    for (int i = 0; i < PPF; i++) if (obs_d[i] != '0) bad++;
    chk(bad == 0, "R5 no read before frame start", bad, 0);
    bad = 0; bf = 0;
    for (int i = 0; i < PPF; i++) begin
      if (obs_d[PPF + i] != DW'(8'h21 + i)) bad++;
      if (!obs_f[PPF + i]) bf++;
    end
    chk(bad == 0, "R5 R2 frame read in order", int'(obs_d[PPF]), 8'h21);
    chk(bf == 0, "R8 stream field bit", bf, 0);
    chk(obs_d[2 * PPF] == '0 && underflow_o, "R9 underflow in master",
        int'(obs_d[2 * PPF]), 0);
    chk(ce_drop == 0, "R5 enable never drops", ce_drop, 0);
    chk(tmis == 0, "R7 timing delay master", tmis, 0);
    chk(zbad == 0, "R8 zero outside active master", zbad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pix_clk);
    t_slave();
    t_master();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule